// File: doc/BRIEF.md
# Fetch-Block Execution Breakpoint Detector

This block checks each 16-byte aligned instruction fetch block against a set of hardware breakpoint slots once, before the block is split into instructions. The fetch side presents the block address, with the four offset bits dropped, together with a valid strobe. A breakpoint control unit supplies, for each slot, a full address, an enable, a two-bit condition code and a two-bit width code.

Each slot is compared on its address bits above the block offset. When a slot's block matches, its low four bits are decoded one-hot to mark the armed byte inside the block. One comparator set serves the whole block, no matter how many instructions the block later yields.

One cycle after the fetch, the block registers three outputs:
- a per-byte mask that is the OR of all matching slots,
- a hit flag,
- the index of the lowest-numbered matching slot.

Top module: `fetch_bp_detect`

## Requirements
- R1: While the active-low reset is asserted, bp_mask, bp_hit and bp_slot are all zero.
- R2: The outputs reflect the fetch presented one clock earlier. A cycle with fetch_vld low yields zero outputs on the next cycle, whatever the slot configuration.
- R3: A slot matches only when its address bits [ADDR_W-1:4] equal fetch_blk. A slot address in the adjacent 16-byte block never matches.
- R4: A matching slot's address bits [3:0] set exactly bp_mask bit at that offset. For example, offset 3 sets bit 3 and offset 15 sets bit 15.
- R5: A slot takes part only when its enable bit is 1 and its condition code is 00 (execute). Condition codes 01 (write), 10 (port I/O) and 11 (read/write), and a cleared enable, give no hit.
- R6: An enabled execute slot whose width code is not 00 (one byte) is ignored.
- R7: bp_mask is the bitwise OR of the decoded masks of all matching slots. Two slots with the same offset set a single bit.
- R8: bp_hit is 1 exactly when bp_mask is non-zero.
- R9: bp_slot gives the lowest-numbered matching slot, and is 0 when there is no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_vld | input | 1 | Fetch block address is valid this cycle |
| fetch_blk | input | ADDR_W-4 | Fetch block address (address bits [ADDR_W-1:4]) |
| slot_addr | input | NUM_SLOTS*ADDR_W | Slot addresses, slot i in bits [i*ADDR_W +: ADDR_W] |
| slot_en | input | NUM_SLOTS | Per-slot enable |
| slot_cond | input | 2*NUM_SLOTS | Per-slot condition code, slot i in bits [2i+1:2i] |
| slot_len | input | 2*NUM_SLOTS | Per-slot width code, slot i in bits [2i+1:2i] |
| bp_mask | output | 16 | Armed byte offsets in the block (registered) |
| bp_hit | output | 1 | Any slot matched (registered) |
| bp_slot | output | clog2(NUM_SLOTS) | Lowest matching slot index (registered) |

## Verification
The first pattern is a single slot at offsets 0, 3 and 15 in the fetched block. It separates a correct one-hot decode from a shifted or inverted one. Slots placed one block above and one block below the fetch address show whether a low offset bit leaks into the tag compare.

Each non-execute condition code and each non-byte width is tried on an otherwise matching slot, which exposes a qualifier that is dropped or misdecoded. Several slots in one block are then tried:
- distinct offsets, which test the OR;
- a shared offset, which tests that it sets one bit;
- varying subsets, which show whether the index picks the lowest or the highest matching slot.

Cycles with the strobe low separate a gated register from a free-running one.

// File: rtl/bpdet_pkg.sv
package bpdet_pkg;
  localparam int BLK_BYTES = 16;
  localparam int OFS_W     = $clog2(BLK_BYTES);

  typedef enum logic [1:0] {
    BRK_EXEC  = 2'b00,
    BRK_WRITE = 2'b01,
    BRK_PORT  = 2'b10,
    BRK_RDWR  = 2'b11
  } brk_cond_e;

  localparam logic [1:0] WID_BYTE = 2'b00;

  function automatic logic [BLK_BYTES-1:0] ofs_onehot(input logic [OFS_W-1:0] ofs);
    ofs_onehot = '0;
    ofs_onehot[ofs] = 1'b1;
  endfunction

  function automatic logic slot_qualifies(input logic en, input logic [1:0] cond,
                                          input logic [1:0] len);
    slot_qualifies = en && (cond == BRK_EXEC) && (len == WID_BYTE);
  endfunction
endpackage

// File: rtl/bpdet_slot.sv
module bpdet_slot
  import bpdet_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int TAG_W = ADDR_W - OFS_W
) (
  input  logic [TAG_W-1:0]     fetch_tag,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 en,
  input  logic [1:0]           cond,
  input  logic [1:0]           len,
  output logic                 elig,
  output logic                 match,
  output logic [BLK_BYTES-1:0] mask
);
  logic tag_eq;

  assign elig   = slot_qualifies(en, cond, len);
  assign tag_eq = (addr[ADDR_W-1:OFS_W] == fetch_tag);
  assign match  = elig && tag_eq;
  assign mask   = match ? ofs_onehot(addr[OFS_W-1:0]) : '0;
endmodule

// File: rtl/bpdet_prio.sv
module bpdet_prio #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/fetch_bp_detect.sv
module fetch_bp_detect
  import bpdet_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_SLOTS = 4,
  localparam int TAG_W  = ADDR_W - OFS_W,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fetch_vld,
  input  logic [TAG_W-1:0]            fetch_blk,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slot_addr,
  input  logic [NUM_SLOTS-1:0]        slot_en,
  input  logic [2*NUM_SLOTS-1:0]      slot_cond,
  input  logic [2*NUM_SLOTS-1:0]      slot_len,
  output logic [BLK_BYTES-1:0]        bp_mask,
  output logic                        bp_hit,
  output logic [SLOT_W-1:0]           bp_slot
);
  logic [NUM_SLOTS-1:0] slot_elig_vec;
  logic [NUM_SLOTS-1:0] slot_hit_vec;
  logic [BLK_BYTES-1:0] slot_mask [NUM_SLOTS];
  logic [BLK_BYTES-1:0] mask_or;
  logic [SLOT_W-1:0]    first_idx;
  logic                 any_hit;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    bpdet_slot #(.ADDR_W(ADDR_W)) u_slot (
      .fetch_tag (fetch_blk),
      .addr      (slot_addr[s*ADDR_W +: ADDR_W]),
      .en        (slot_en[s]),
      .cond      (slot_cond[2*s +: 2]),
      .len       (slot_len[2*s +: 2]),
      .elig      (slot_elig_vec[s]),
      .match     (slot_hit_vec[s]),
      .mask      (slot_mask[s])
    );
  end

  always_comb begin
    mask_or = '0;
    for (int s = 0; s < NUM_SLOTS; s++) mask_or = mask_or | slot_mask[s];
  end

  bpdet_prio #(.N(NUM_SLOTS)) u_prio (
    .req (slot_hit_vec),
    .idx (first_idx),
    .any (any_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_mask <= '0;
      bp_hit  <= 1'b0;
      bp_slot <= '0;
    end else if (!fetch_vld) begin
      bp_mask <= '0;
      bp_hit  <= 1'b0;
      bp_slot <= '0;
    end else begin
      bp_mask <= mask_or;
      bp_hit  <= any_hit;
      bp_slot <= first_idx;
    end
  end
endmodule

// File: rtl/fetch_bp_detect_chk.sv
module fetch_bp_detect_chk #(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fetch_vld,
  input logic [15:0]          bp_mask,
  input logic                 bp_hit,
  input logic [SLOT_W-1:0]    bp_slot,
  input logic [NUM_SLOTS-1:0] hit_vec,
  input logic [NUM_SLOTS-1:0] elig_vec
);
  logic [NUM_SLOTS-1:0] hv_q;
  logic [NUM_SLOTS-1:0] below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hv_q <= '0;
    else        hv_q <= fetch_vld ? hit_vec : '0;
  end

  assign below = (NUM_SLOTS'(1) << bp_slot) - NUM_SLOTS'(1);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (bp_mask == '0 && !bp_hit && bp_slot == '0)); // R1

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld |=> (bp_mask == '0 && !bp_hit && bp_slot == '0)); // R2

  AST_HIT_ONLY_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & ~elig_vec) == '0); // R5

  AST_HIT_IFF_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    bp_hit == (bp_mask != '0)); // R8

  AST_LOWEST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    bp_hit |-> (hv_q[bp_slot] && ((hv_q & below) == '0))); // R9

  AST_MASK_BITS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bp_hit |-> ($countones(bp_mask) <= $countones(hv_q))); // R7
endmodule

bind fetch_bp_detect fetch_bp_detect_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fetch_vld (fetch_vld),
  .bp_mask   (bp_mask),
  .bp_hit    (bp_hit),
  .bp_slot   (bp_slot),
  .hit_vec   (slot_hit_vec),
  .elig_vec  (slot_elig_vec)
);

// File: tb/tb_fetch_bp_detect.sv
`timescale 1ns/1ps
module tb_fetch_bp_detect;
  localparam int AW = 32;
  localparam int NS = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            fetch_vld = 1'b0;
  logic [AW-5:0]   fetch_blk = '0;
  logic [NS*AW-1:0] slot_addr = '0;
  logic [NS-1:0]   slot_en = '0;
  logic [2*NS-1:0] slot_cond = '0;
  logic [2*NS-1:0] slot_len = '0;
  logic [15:0]     bp_mask;
  logic            bp_hit;
  logic [1:0]      bp_slot;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  fetch_bp_detect #(.ADDR_W(AW), .NUM_SLOTS(NS)) dut (
    .clk, .rst_n, .fetch_vld, .fetch_blk, .slot_addr, .slot_en,
    .slot_cond, .slot_len, .bp_mask, .bp_hit, .bp_slot
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_slot(input int s, input logic [31:0] a, input logic en,
                          input logic [1:0] c, input logic [1:0] l);
    slot_addr[s*AW +: AW] = a;
    slot_en[s]            = en;
    slot_cond[2*s +: 2]   = c;
    slot_len[2*s +: 2]    = l;
  endtask

  task automatic clear_slots();
    for (int s = 0; s < NS; s++) set_slot(s, 32'h0, 1'b0, 2'b00, 2'b00);
  endtask

  // Present one fetch, wait for the capturing edge, compare against a model.
  task automatic fetch_and_check(input string req, input logic v, input logic [31:0] addr);
    logic [15:0] em;
    logic [1:0]  es;
    logic        eh;
    @(negedge clk);
    fetch_vld = v;
    fetch_blk = addr[31:4];
    em = '0; es = '0; eh = 1'b0;
    if (v) begin
      for (int s = NS - 1; s >= 0; s--) begin
        logic [31:0] sa;
        sa = slot_addr[s*AW +: AW];
        if (slot_en[s] && slot_cond[2*s +: 2] == 2'b00 && slot_len[2*s +: 2] == 2'b00
            && (sa >> 4) == (addr >> 4)) begin
          em = em | (16'h1 << sa[3:0]);
          es = 2'(s);
          eh = 1'b1;
        end
      end
    end
    @(posedge clk);
    #1;
    chk(req, "mask", 32'(bp_mask), 32'(em));
    chk(req, "hit",  32'(bp_hit),  32'(eh));
    chk(req, "slot", 32'(bp_slot), 32'(es));
    chk("R8", "hit_vs_mask", 32'(bp_hit), 32'(bp_mask != 16'h0));
    @(negedge clk);
    fetch_vld = 1'b0;
  endtask

  task automatic t_reset();
    clear_slots();
    set_slot(0, 32'h0040_1003, 1'b1, 2'b00, 2'b00);
    fetch_vld = 1'b1;
    fetch_blk = 28'h0040100;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "mask", 32'(bp_mask), 32'h0);
    chk("R1", "hit",  32'(bp_hit),  32'h0);
    chk("R1", "slot", 32'(bp_slot), 32'h0);
    @(negedge clk);
    fetch_vld = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic t_decode();
    clear_slots();
    set_slot(0, 32'h0040_1003, 1'b1, 2'b00, 2'b00);
    fetch_and_check("R4", 1'b1, 32'h0040_1000);
    chk("R4", "bit3", 32'(bp_mask), 32'h0000_0008);
    set_slot(0, 32'h0040_1000, 1'b1, 2'b00, 2'b00);
    fetch_and_check("R4", 1'b1, 32'h0040_1000);
    set_slot(0, 32'h0040_100F, 1'b1, 2'b00, 2'b00);
    fetch_and_check("R4", 1'b1, 32'h0040_1000);
  endtask

  task automatic t_tag();
    clear_slots();
    set_slot(1, 32'h0040_1010, 1'b1, 2'b00, 2'b00);
    set_slot(2, 32'h0040_0FFF, 1'b1, 2'b00, 2'b00);
    fetch_and_check("R3", 1'b1, 32'h0040_1000);
    chk("R3", "no_neighbour_hit", 32'(bp_hit), 32'h0);
    set_slot(3, 32'hA040_1005, 1'b1, 2'b00, 2'b00);
    fetch_and_check("R3", 1'b1, 32'h0040_1000);
    fetch_and_check("R3", 1'b1, 32'hA040_1000);
  endtask

  task automatic t_cond();
    for (int c = 1; c < 4; c++) begin
      clear_slots();
      set_slot(0, 32'h0000_2004, 1'b1, 2'(c), 2'b00);
      fetch_and_check("R5", 1'b1, 32'h0000_2000);
      chk("R5", "cond_ignored", 32'(bp_hit), 32'h0);
    end
    clear_slots();
    set_slot(0, 32'h0000_2004, 1'b0, 2'b00, 2'b00);
    fetch_and_check("R5", 1'b1, 32'h0000_2000);
  endtask

  task automatic t_len();
    for (int l = 1; l < 4; l++) begin
      clear_slots();
      set_slot(2, 32'h0000_3008, 1'b1, 2'b00, 2'(l));
      fetch_and_check("R6", 1'b1, 32'h0000_3000);
      chk("R6", "len_ignored", 32'(bp_mask), 32'h0);
    end
  endtask

  task automatic t_or_prio();
    clear_slots();
    set_slot(1, 32'h0000_4002, 1'b1, 2'b00, 2'b00);
    set_slot(3, 32'h0000_400F, 1'b1, 2'b00, 2'b00);
    fetch_and_check("R7", 1'b1, 32'h0000_4000);
    chk("R7", "or_mask", 32'(bp_mask), 32'h0000_8004);
    chk("R9", "lowest", 32'(bp_slot), 32'h1);
    set_slot(2, 32'h0000_4002, 1'b1, 2'b00, 2'b00);
    set_slot(1, 32'h0000_4002, 1'b0, 2'b00, 2'b00);
    fetch_and_check("R9", 1'b1, 32'h0000_4000);
    chk("R9", "lowest", 32'(bp_slot), 32'h2);
    set_slot(0, 32'h0000_4002, 1'b1, 2'b00, 2'b00);
    fetch_and_check("R7", 1'b1, 32'h0000_4000);
    chk("R7", "shared_bit", 32'(bp_mask), 32'h0000_8004);
    chk("R9", "lowest", 32'(bp_slot), 32'h0);
  endtask

  task automatic t_valid();
    clear_slots();
    set_slot(3, 32'h0000_5007, 1'b1, 2'b00, 2'b00);
    fetch_and_check("R2", 1'b1, 32'h0000_5000);
    fetch_and_check("R2", 1'b0, 32'h0000_5000);
    chk("R2", "idle_clear", 32'(bp_mask), 32'h0);
    fetch_and_check("R2", 1'b1, 32'h0000_5000);
    chk("R2", "rearm", 32'(bp_slot), 32'h3);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_decode();
    t_tag();
    t_cond();
    t_len();
    t_or_prio();
    t_valid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule